// File: doc/BRIEF.md
# Two-Way Translation Buffer with Hardware Refill

This block keeps a small set-associative store of recent page mappings and turns a 40-bit virtual address into a 36-bit physical address. Pages are 16 KB, so the low 14 address bits pass through unchanged. The 26-bit page number is split into two fields: its low 8 bits select one of 256 sets, and its upper 18 bits are compared against the tag held in each of the two ways of that set. When a lookup finds no matching entry, the block asks an external table walker for the mapping. It then installs the returned entry and repeats the lookup, so software never handles a refill.

The block is driven by a three-state machine. In `ST_IDLE` the block shows `req_ready` and takes a request. A request accepted in `ST_IDLE` always moves it to `ST_LOOK`, which compares the tags and answers in the cycle that follows acceptance. From `ST_LOOK`, a hit moves back to `ST_IDLE` and a miss moves to `ST_WALK`. `ST_WALK` raises `walk_req` and stays there until `walk_ack`. If the walker reports that the page is present, the entry is written and the block returns to `ST_LOOK`. If the page is absent, the block answers with a page fault and returns to `ST_IDLE`.

Each entry also carries rights, dirty and reference state. A refill takes an empty way first. When the set is full, the refill replaces the way whose reference bit is clear.

Top module: `tlb_xlate`

## Requirements
- R1: When a lookup hits and the access is permitted, `resp_valid` is high in the cycle after acceptance, and `resp_paddr` is the entry's 22-bit physical page number above the request's untouched 14-bit offset.
- R2: A miss gives no response in its lookup cycle. In the following cycles `walk_req` stays high with `walk_vpn` equal to address bits 39:14, and `req_ready` stays low, until `walk_ack`.
- R3: A present refill is written into the lowest-numbered empty way of the set indexed by page-number bits 7:0.
- R4: When both ways of the set are valid, a refill replaces the way whose reference bit is 0, taking the lowest-numbered such way. A hit sets the reference bit of the way it hit.
- R5: When setting a reference bit would leave every reference bit of the set at 1, the other ways' bits are cleared.
- R6: If `walk_present` is low when `walk_ack` arrives, the block gives a response in that same cycle with `resp_page_fault` high and `resp_paddr` zero. Nothing is installed, so a repeat of the access misses again.
- R7: Rights bit 0 allows reads, bit 1 allows writes and bit 2 allows accesses with `req_user` high. A hit that lacks a required right responds with `resp_perm_fault` high and `resp_paddr` zero.
- R8: A permitted write hit sets the entry's dirty bit. `resp_dirty` shows the entry's dirty state after the access, and a newly installed entry starts clean.
- R9: A one-cycle `flush` invalidates every entry, so every later access misses.
- R10: After a present refill, the block repeats the lookup, and the response appears in the cycle after `walk_ack`.
- R11: After reset, `req_ready` is high and both `walk_req` and `resp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush | input | 1 | Invalidate all entries |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block idle, request taken |
| req_vaddr | input | 40 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access from user mode |
| resp_valid | output | 1 | Response strobe |
| resp_paddr | output | 36 | Physical address, zero on fault |
| resp_dirty | output | 1 | Entry dirty after access |
| resp_perm_fault | output | 1 | Rights violation |
| resp_page_fault | output | 1 | Page not present |
| walk_req | output | 1 | Refill request to walker |
| walk_vpn | output | 26 | Page number to walk |
| walk_ack | input | 1 | Walker result valid |
| walk_present | input | 1 | Page is in memory |
| walk_ppn | input | 22 | Returned physical page number |
| walk_rights | input | 3 | Returned rights |

## Verification
The bench builds the block with its default parameters: 40/36-bit addresses, 16 KB pages, 256 sets and 2 ways. It drives several tags into a single set, so that sequence of hits and evictions shows the reference-bit policy at the ports. Walker latencies from zero to three cycles cover both a refill acknowledged on the first walk cycle and a refill that waits. The bench steps a behavioural copy of the sets alongside the block and compares its predicted response with the block's output in every cycle of each access.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int unsigned DEF_VA_W   = 40;
    localparam int unsigned DEF_PA_W   = 36;
    localparam int unsigned DEF_OFF_W  = 14;
    localparam int unsigned DEF_SETS   = 256;
    localparam int unsigned DEF_WAYS   = 2;
    localparam int unsigned RIGHTS_W   = 3;
    localparam int unsigned RT_READ    = 0;
    localparam int unsigned RT_WRITE   = 1;
    localparam int unsigned RT_USER    = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOK,
        ST_WALK
    } tlb_state_e;
endpackage

// File: rtl/tlb_way.sv
module tlb_way #(
    parameter int unsigned SETS  = 256,
    parameter int unsigned TAG_W = 18,
    parameter int unsigned PPN_W = 22,
    parameter int unsigned RTS_W = 3,
    parameter int unsigned IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [IDX_W-1:0] idx,
    input  logic [TAG_W-1:0] cmp_tag,
    output logic             o_valid,
    output logic             o_hit,
    output logic [PPN_W-1:0] o_ppn,
    output logic [RTS_W-1:0] o_rights,
    output logic             o_dirty,
    output logic             o_ref,
    input  logic             fill_en,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic [RTS_W-1:0] fill_rights,
    input  logic             dirty_set,
    input  logic             ref_set,
    input  logic             ref_clr
);
    logic [SETS-1:0]  valid_q;
    logic [SETS-1:0]  dirty_q;
    logic [SETS-1:0]  ref_q;
    logic [TAG_W-1:0] tag_q    [SETS];
    logic [PPN_W-1:0] ppn_q    [SETS];
    logic [RTS_W-1:0] rights_q [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
            ref_q   <= '0;
        end else if (flush) begin
            valid_q <= '0;
            ref_q   <= '0;
        end else begin
            if (fill_en) begin
                valid_q[idx] <= 1'b1;
                dirty_q[idx] <= 1'b0;
            end
            if (dirty_set) dirty_q[idx] <= 1'b1;
            if (ref_clr)   ref_q[idx]   <= 1'b0;
            if (ref_set)   ref_q[idx]   <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en && !flush) begin
            tag_q[idx]    <= fill_tag;
            ppn_q[idx]    <= fill_ppn;
            rights_q[idx] <= fill_rights;
        end
    end

    always_comb begin
        o_valid  = valid_q[idx];
        o_hit    = valid_q[idx] && (tag_q[idx] == cmp_tag);
        o_ppn    = ppn_q[idx];
        o_rights = rights_q[idx];
        o_dirty  = dirty_q[idx];
        o_ref    = ref_q[idx];
    end

    // R9
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0));
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int unsigned WAYS  = 2,
    parameter int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]  valid,
    input  logic [WAYS-1:0]  refb,
    output logic [WAY_W-1:0] victim
);
    logic got;

    always_comb begin
        victim = '0;
        got    = 1'b0;
        for (int i = 0; i < WAYS; i++) begin
            if (!got && !valid[i]) begin
                victim = WAY_W'(i);
                got    = 1'b1;
            end
        end
        for (int i = 0; i < WAYS; i++) begin
            if (!got && !refb[i]) begin
                victim = WAY_W'(i);
                got    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int unsigned VA_W  = DEF_VA_W,
    parameter int unsigned PA_W  = DEF_PA_W,
    parameter int unsigned OFF_W = DEF_OFF_W,
    parameter int unsigned SETS  = DEF_SETS,
    parameter int unsigned WAYS  = DEF_WAYS
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [VA_W-1:0]           req_vaddr,
    input  logic                      req_write,
    input  logic                      req_user,
    output logic                      resp_valid,
    output logic [PA_W-1:0]           resp_paddr,
    output logic                      resp_dirty,
    output logic                      resp_perm_fault,
    output logic                      resp_page_fault,
    output logic                      walk_req,
    output logic [VA_W-OFF_W-1:0]     walk_vpn,
    input  logic                      walk_ack,
    input  logic                      walk_present,
    input  logic [PA_W-OFF_W-1:0]     walk_ppn,
    input  logic [RIGHTS_W-1:0]       walk_rights
);
    localparam int unsigned VPN_W = VA_W - OFF_W;
    localparam int unsigned PPN_W = PA_W - OFF_W;
    localparam int unsigned IDX_W = $clog2(SETS);
    localparam int unsigned TAG_W = VPN_W - IDX_W;
    localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    tlb_state_e state_q, state_d;
    logic [VA_W-1:0] va_q;
    logic            wr_q, usr_q;

    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tag;
    assign idx      = va_q[OFF_W +: IDX_W];
    assign tag      = va_q[VA_W-1 -: TAG_W];
    assign walk_vpn = va_q[VA_W-1:OFF_W];

    logic [WAYS-1:0]     w_valid, w_hit, w_dirty, w_ref;
    logic [PPN_W-1:0]    w_ppn    [WAYS];
    logic [RIGHTS_W-1:0] w_rights [WAYS];

    logic [WAY_W-1:0] hit_way, victim;
    logic             hit_any, perm_bad, ref_full;
    logic             fill_go, dirty_go, touch_go;
    logic [PPN_W-1:0]    sel_ppn;
    logic [RIGHTS_W-1:0] sel_rights;
    logic                sel_dirty;

    // ---------------- way storage ----------------
    for (genvar g = 0; g < WAYS; g++) begin : g_way
        tlb_way #(
            .SETS (SETS), .TAG_W(TAG_W), .PPN_W(PPN_W), .RTS_W(RIGHTS_W)
        ) u_way (
            .clk        (clk),
            .rst_n      (rst_n),
            .flush      (flush),
            .idx        (idx),
            .cmp_tag    (tag),
            .o_valid    (w_valid[g]),
            .o_hit      (w_hit[g]),
            .o_ppn      (w_ppn[g]),
            .o_rights   (w_rights[g]),
            .o_dirty    (w_dirty[g]),
            .o_ref      (w_ref[g]),
            .fill_en    (fill_go && (victim == WAY_W'(g))),
            .fill_tag   (tag),
            .fill_ppn   (walk_ppn),
            .fill_rights(walk_rights),
            .dirty_set  (dirty_go && (hit_way == WAY_W'(g))),
            .ref_set    (touch_go && (hit_way == WAY_W'(g))),
            .ref_clr    (touch_go && ref_full && (hit_way != WAY_W'(g)))
        );
    end

    tlb_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
        .valid (w_valid),
        .refb  (w_ref),
        .victim(victim)
    );

    // ---------------- hit select and rights ----------------
    always_comb begin
        hit_way = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (w_hit[i]) hit_way = WAY_W'(i);
        end
    end

    assign hit_any    = |w_hit;
    assign sel_ppn    = w_ppn[hit_way];
    assign sel_rights = w_rights[hit_way];
    assign sel_dirty  = w_dirty[hit_way];
    assign ref_full   = &(w_ref | w_hit);
    assign perm_bad   = (wr_q  && !sel_rights[RT_WRITE]) ||
                        (!wr_q && !sel_rights[RT_READ])  ||
                        (usr_q && !sel_rights[RT_USER]);

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q  <= '0;
            wr_q  <= 1'b0;
            usr_q <= 1'b0;
        end else if (state_q == ST_IDLE && req_valid) begin
            va_q  <= req_vaddr;
            wr_q  <= req_write;
            usr_q <= req_user;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_LOOK;
            ST_LOOK: state_d = hit_any ? ST_IDLE : ST_WALK;
            ST_WALK: if (walk_ack) state_d = walk_present ? ST_LOOK : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        req_ready       = 1'b0;
        resp_valid      = 1'b0;
        resp_paddr      = '0;
        resp_dirty      = 1'b0;
        resp_perm_fault = 1'b0;
        resp_page_fault = 1'b0;
        walk_req        = 1'b0;
        fill_go         = 1'b0;
        dirty_go        = 1'b0;
        touch_go        = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_LOOK: begin
                if (hit_any) begin
                    resp_valid = 1'b1;
                    touch_go   = 1'b1;
                    if (perm_bad) begin
                        resp_perm_fault = 1'b1;
                    end else begin
                        resp_paddr = {sel_ppn, va_q[OFF_W-1:0]};
                        resp_dirty = sel_dirty | wr_q;
                        dirty_go   = wr_q & ~sel_dirty;
                    end
                end
            end
            ST_WALK: begin
                walk_req = 1'b1;
                if (walk_ack) begin
                    if (walk_present) begin
                        fill_go = 1'b1;
                    end else begin
                        resp_valid      = 1'b1;
                        resp_page_fault = 1'b1;
                    end
                end
            end
            default: ;
        endcase
    end

    // ---------------- assertions ----------------
    // R1
    accept_to_look_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (state_q == ST_LOOK));
    // R1
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_perm_fault && !resp_page_fault)
            |-> (resp_paddr[OFF_W-1:0] == va_q[OFF_W-1:0]));
    // R2
    walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && !walk_ack) |=> (walk_req && $stable(walk_vpn)));
    // R3
    fill_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_go && !(&w_valid)) |-> !w_valid[victim]);
    // R6
    fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !(resp_perm_fault && resp_page_fault));
    // R7
    fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && (resp_perm_fault || resp_page_fault)) |-> (resp_paddr == '0));
endmodule

// File: tb/sim_tlb_xlate.sv
`timescale 1ns/1ps
module sim_tlb_xlate;
    localparam int NSETS = 256;
    localparam int NWAYS = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [39:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        resp_valid;
    logic [35:0] resp_paddr;
    logic        resp_dirty, resp_perm_fault, resp_page_fault;
    logic        walk_req;
    logic [25:0] walk_vpn;
    logic        walk_ack = 1'b0;
    logic        walk_present = 1'b0;
    logic [21:0] walk_ppn = '0;
    logic [2:0]  walk_rights = '0;

    always #2 clk = ~clk;

    tlb_xlate u0 (.*);

    int vectors = 0;
    int fails   = 0;

    bit          m_valid  [NSETS][NWAYS];
    bit          m_ref    [NSETS][NWAYS];
    bit          m_dirty  [NSETS][NWAYS];
    logic [17:0] m_tag    [NSETS][NWAYS];
    logic [21:0] m_ppn    [NSETS][NWAYS];
    logic [2:0]  m_rights [NSETS][NWAYS];
    bit          was_miss;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [21:0] ppn_of(input logic [25:0] v);
        return 22'(v * 5 + 11);
    endfunction

    function automatic int find_way(input int idx, input logic [17:0] tg);
        for (int i = 0; i < NWAYS; i++)
            if (m_valid[idx][i] && m_tag[idx][i] == tg) return i;
        return -1;
    endfunction

    function automatic int pick_victim(input int idx);
        for (int i = 0; i < NWAYS; i++) if (!m_valid[idx][i]) return i;
        for (int i = 0; i < NWAYS; i++) if (!m_ref[idx][i]) return i;
        return 0;
    endfunction

    task automatic respond(input int idx, input int w, input logic [39:0] va,
                           input bit wr, input bit usr, input string req);
        logic [2:0] r;
        bit bad, all1;
        r = m_rights[idx][w];
        bad = (wr && !r[1]) || (!wr && !r[0]) || (usr && !r[2]);
        chk(resp_valid == 1'b1, req, "resp_valid on hit", resp_valid, 1);
        if (bad) begin
            chk(resp_perm_fault && !resp_page_fault && resp_paddr == '0, "R7",
                "rights fault", {resp_perm_fault, resp_paddr}, {1'b1, 36'h0});
        end else begin
            chk(resp_paddr == {m_ppn[idx][w], va[13:0]} && !resp_perm_fault, req,
                "paddr", resp_paddr, {m_ppn[idx][w], va[13:0]});
            chk(resp_dirty == (m_dirty[idx][w] | wr), "R8", "dirty",
                resp_dirty, m_dirty[idx][w] | wr);
            if (wr) m_dirty[idx][w] = 1'b1;
        end
        m_ref[idx][w] = 1'b1;
        all1 = 1'b1;
        for (int i = 0; i < NWAYS; i++) if (!m_ref[idx][i]) all1 = 1'b0;
        if (all1) for (int i = 0; i < NWAYS; i++) if (i != w) m_ref[idx][i] = 1'b0;
    endtask

    task automatic access(input logic [39:0] va, input bit wr, input bit usr,
                          input bit present, input logic [2:0] rts, input int delay);
        logic [25:0] vpn;
        logic [17:0] tg;
        int idx, w;
        vpn = va[39:14];
        idx = int'(vpn[7:0]);
        tg  = vpn[25:8];
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_write = wr; req_user = usr;
        @(negedge clk);
        req_valid = 1'b0;
        w = find_way(idx, tg);
        was_miss = (w < 0);
        if (w >= 0) begin
            respond(idx, w, va, wr, usr, "R1");
            return;
        end
        chk(resp_valid == 1'b0, "R2", "no response on miss", resp_valid, 0);
        @(negedge clk);
        for (int i = 0; i < delay; i++) begin
            chk(walk_req && walk_vpn == vpn, "R2", "walk held", walk_vpn, vpn);
            chk(req_ready == 1'b0, "R2", "busy while walking", req_ready, 0);
            @(negedge clk);
        end
        chk(walk_req && walk_vpn == vpn, "R2", "walk request", walk_vpn, vpn);
        walk_ack = 1'b1; walk_present = present; walk_ppn = ppn_of(vpn); walk_rights = rts;
        #1;
        if (!present) begin
            chk(resp_valid && resp_page_fault && !resp_perm_fault && resp_paddr == '0, "R6",
                "page fault", {resp_valid, resp_page_fault}, 2'b11);
            @(negedge clk);
            walk_ack = 1'b0;
            return;
        end
        chk(resp_valid == 1'b0, "R10", "no response on ack", resp_valid, 0);
        @(negedge clk);
        walk_ack = 1'b0;
        w = pick_victim(idx);
        m_valid[idx][w]  = 1'b1;
        m_dirty[idx][w]  = 1'b0;
        m_tag[idx][w]    = tg;
        m_ppn[idx][w]    = ppn_of(vpn);
        m_rights[idx][w] = rts;
        respond(idx, w, va, wr, usr, "R10");
    endtask

    function automatic logic [39:0] mkva(input logic [17:0] tg, input logic [7:0] ix,
                                         input logic [13:0] off);
        return {tg, ix, off};
    endfunction

    initial begin
        #(4 * 100000);
        fails++; vectors++;
        $display("FAIL R11 watchdog: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        for (int s = 0; s < NSETS; s++)
            for (int i = 0; i < NWAYS; i++) begin
                m_valid[s][i] = 0; m_ref[s][i] = 0; m_dirty[s][i] = 0;
            end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(req_ready && !walk_req && !resp_valid, "R11", "reset outputs",
            {req_ready, walk_req, resp_valid}, 3'b100);

        // R3 / R10: first fill into way 0, then hit (R1)
        access(mkva(18'h1, 8'h05, 14'h0123), 0, 0, 1, 3'b111, 0);
        chk(was_miss == 1, "R3", "first access misses", was_miss, 1);
        access(mkva(18'h1, 8'h05, 14'h3ffe), 0, 0, 1, 3'b111, 0);
        chk(was_miss == 0, "R1", "repeat access hits", was_miss, 0);
        // R3 second tag fills the empty way, first stays
        access(mkva(18'h2, 8'h05, 14'h0001), 0, 0, 1, 3'b111, 2);
        access(mkva(18'h1, 8'h05, 14'h0040), 0, 0, 1, 3'b111, 0);
        chk(was_miss == 0, "R3", "empty way used, old entry kept", was_miss, 0);
        // R4 / R5 replacement by reference bits
        access(mkva(18'h3, 8'h05, 14'h0200), 0, 0, 1, 3'b111, 1);
        access(mkva(18'h1, 8'h05, 14'h0002), 0, 0, 1, 3'b111, 0);
        chk(was_miss == 0, "R4", "recently used way kept", was_miss, 0);
        access(mkva(18'h2, 8'h05, 14'h0003), 0, 0, 1, 3'b111, 3);
        chk(was_miss == 1, "R4", "unreferenced way evicted", was_miss, 1);
        access(mkva(18'h1, 8'h05, 14'h0004), 0, 0, 1, 3'b111, 0);
        chk(was_miss == 0, "R5", "ref reset keeps hit way", was_miss, 0);
        access(mkva(18'h3, 8'h05, 14'h0005), 0, 0, 1, 3'b111, 0);
        chk(was_miss == 1, "R5", "cleared ref way evicted", was_miss, 1);

        // R8 dirty tracking
        access(mkva(18'h7, 8'h20, 14'h0010), 0, 0, 1, 3'b111, 0);
        access(mkva(18'h7, 8'h20, 14'h0011), 1, 0, 1, 3'b111, 0);
        access(mkva(18'h7, 8'h20, 14'h0012), 0, 0, 1, 3'b111, 0);
        chk(resp_dirty == 1, "R8", "dirty persists", resp_dirty, 1);

        // R7 rights faults
        access(mkva(18'h9, 8'h31, 14'h0100), 1, 0, 1, 3'b101, 0);
        access(mkva(18'ha, 8'h32, 14'h0100), 0, 1, 1, 3'b011, 1);
        access(mkva(18'hb, 8'h33, 14'h0100), 0, 0, 1, 3'b010, 0);
        access(mkva(18'h9, 8'h31, 14'h0101), 0, 0, 1, 3'b101, 0);
        chk(resp_perm_fault == 0, "R7", "permitted read ok", resp_perm_fault, 0);

        // R6 page not present
        access(mkva(18'h2a, 8'h44, 14'h0777), 0, 0, 0, 3'b111, 1);
        access(mkva(18'h2a, 8'h44, 14'h0777), 0, 0, 1, 3'b111, 0);
        chk(was_miss == 1, "R6", "nothing installed on fault", was_miss, 1);

        // R1 spread over sets and offsets
        for (int k = 0; k < 6; k++) begin
            access(mkva(18'(k * 37 + 5), 8'(k * 41 + 3), 14'(k * 2731)), 0, 0, 1, 3'b111, k % 4);
            access(mkva(18'(k * 37 + 5), 8'(k * 41 + 3), 14'(k * 911 + 1)), 0, 0, 1, 3'b111, 0);
            chk(was_miss == 0, "R1", "hit after fill", was_miss, 0);
        end

        // R9 flush
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        for (int s = 0; s < NSETS; s++)
            for (int i = 0; i < NWAYS; i++) begin m_valid[s][i] = 0; m_ref[s][i] = 0; end
        access(mkva(18'h1, 8'h05, 14'h0006), 0, 0, 1, 3'b111, 0);
        chk(was_miss == 1, "R9", "miss after flush", was_miss, 1);
        access(mkva(18'h7, 8'h20, 14'h0013), 0, 0, 1, 3'b111, 0);
        chk(was_miss == 1 && resp_dirty == 0, "R9", "flushed entry refilled clean",
            {was_miss, resp_dirty}, 2'b10);

        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule